// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the write-only configuration port of a high-speed data converter. A host drives three wires, an active-low select, a serial clock and a data line. It shifts in one 32-bit frame per select window, most significant bit first. The frame carries a fixed 12-bit header, a 4-bit register address and a 16-bit value. When select is released after exactly 32 bits, the value is written into one of eight control registers. The block decodes those registers into the converter's control fields: clock mode and phase, output enable and output swing, 9-bit offset and full-scale trims, dual-edge-sampling enable, automatic-phase select and the raw coarse and fine phase words.

The serial pins are oversampled by a faster system clock through two-flop synchronisers with edge detection, so the serial clock may run at any rate up to a fraction of the system clock, with no lower limit. The port only listens while the extended-control input is high.

An initialisation interlock guards dual-edge sampling. The enable output stays low until every one of the eight registers has been written at least once. The first write to the dual-edge register must carry its default value 0x3FFF, or it is refused.

Top module: `serial_cfg_slave`

## Requirements
- R1: After reset the outputs show the default register contents: the config word (address 1h) is 0x0200, so the DDR-disable bit is 0, the clock phase is 0, output enable is 0 and the output level is 1. Offset is 0 and full-scale is 256 (word 0x8000). The dual-edge word is 0x3FFF, so dual-edge enable is 0 and auto phase is 0. The coarse and fine words are 0x0000.
- R2: A frame is 32 bits sent MSB first while select is low, with each bit taken on a rising serial clock. Bits 31..20 are the header 0x001, bits 19..16 are the address and bits 15..0 are the value. The value is written when select returns high.
- R3: A window that held fewer or more than 32 serial clock rises, or whose header is not 0x001, changes no register.
- R4: While the extended-control input is low, frames have no effect on any register.
- R5: In the config word, bit 8 drives output enable, bit 9 drives output level, bit 10 drives the active-low DDR enable and bit 11 drives the DDR clock phase.
- R6: When a config write has bit 10 at 0 (DDR mode), bit 8 is stored as 0 whatever value was sent.
- R7: The offset output is bits 15..7 of word 2h, and the full-scale output is bits 15..7 of word 3h.
- R8: In word Dh, bit 15 requests dual-edge sampling and bit 14 selects automatic phase. The dual-edge enable output is high only when bit 15 is set and all eight registers have been written.
- R9: The first write to Dh after reset is stored only if its value is exactly 0x3FFF. A refused write does not count as written.
- R10: Addresses 0h and 4h are stored and count toward the interlock but drive no output. Addresses 5h..Ch are ignored and do not count.
- R11: The coarse and fine outputs carry the full 16-bit words at Eh and Fh.
- R12: The synchronous reset restores every default and clears all written-once flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode_i | input | 1 | Extended-control enable for the serial port |
| sel_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data, MSB first |
| ddr_n_o | output | 1 | DDR clocking disable (0 = DDR) |
| ddr_phase_o | output | 1 | DDR clock phase select |
| out_en_o | output | 1 | Output enable |
| out_lvl_o | output | 1 | Output swing select |
| offset_o | output | 9 | Input offset trim |
| fs_adj_o | output | 9 | Full-scale trim |
| des_en_o | output | 1 | Dual-edge sampling enable after interlock |
| auto_phase_o | output | 1 | Automatic clock phase select |
| coarse_o | output | 16 | Coarse phase word |
| fine_o | output | 16 | Fine phase word |

## Verification
The bench sends windows of 31 and 33 bits and a frame with a bad header. A length counter that wrapped or did not saturate would commit these, and the continuous comparison would catch the corrupted outputs. It requests dual-edge sampling before the last register has been written and expects no enable. A design that gated only on the Dh bit would raise the output early. It opens with a non-default Dh write, both after power-up and after a mid-run reset. If the written-once flags survived reset, or the first-write rule were missing, that write would land and change the phase select. It also writes the config word in DDR mode with output enable requested, and expects output enable to stay low.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int FRAME_BITS = 32;
    localparam int HDR_BITS   = 12;
    localparam int ADDR_BITS  = 4;
    localparam int WORD_BITS  = 16;
    localparam int NUM_REGS   = 8;
    localparam int SLOT_BITS  = $clog2(NUM_REGS);
    localparam int TRIM_BITS  = 9;
    localparam int TRIM_LSB   = WORD_BITS - TRIM_BITS;

    localparam logic [HDR_BITS-1:0] HDR_VALUE = 12'h001;

    typedef logic [WORD_BITS-1:0] word_t;

    typedef struct packed {
        logic                 ok;
        logic [SLOT_BITS-1:0] idx;
    } slot_t;

    localparam int SLOT_SPARE0 = 0;
    localparam int SLOT_CFG    = 1;
    localparam int SLOT_OFS    = 2;
    localparam int SLOT_FS     = 3;
    localparam int SLOT_SPARE4 = 4;
    localparam int SLOT_DES    = 5;
    localparam int SLOT_COARSE = 6;
    localparam int SLOT_FINE   = 7;

    localparam int CFG_OE_BIT    = 8;
    localparam int CFG_LVL_BIT   = 9;
    localparam int CFG_DDRN_BIT  = 10;
    localparam int CFG_PHASE_BIT = 11;
    localparam int DES_EN_BIT    = 15;
    localparam int DES_AUTO_BIT  = 14;

    localparam word_t DES_INIT_WORD = 16'h3FFF;

    function automatic slot_t slot_of(input logic [ADDR_BITS-1:0] a);
        slot_t s;
        s.ok  = 1'b1;
        s.idx = '0;
        case (a)
            4'h0:    s.idx = SLOT_BITS'(SLOT_SPARE0);
            4'h1:    s.idx = SLOT_BITS'(SLOT_CFG);
            4'h2:    s.idx = SLOT_BITS'(SLOT_OFS);
            4'h3:    s.idx = SLOT_BITS'(SLOT_FS);
            4'h4:    s.idx = SLOT_BITS'(SLOT_SPARE4);
            4'hD:    s.idx = SLOT_BITS'(SLOT_DES);
            4'hE:    s.idx = SLOT_BITS'(SLOT_COARSE);
            4'hF:    s.idx = SLOT_BITS'(SLOT_FINE);
            default: s.ok  = 1'b0;
        endcase
        return s;
    endfunction

    function automatic word_t reset_word(input int idx);
        case (idx)
            SLOT_CFG: return 16'h0200;
            SLOT_FS:  return 16'h8000;
            SLOT_DES: return DES_INIT_WORD;
            default:  return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] rise
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
        logic [WIDTH-1:0]             prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
        if (rst) begin
            st_d.pipe = {STAGES{RST_VAL}};
            st_d.prev = RST_VAL;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];
    assign rise = st_q.pipe[STAGES-1] & ~st_q.prev;

endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
    import cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 sel_n,
    input  logic                 sel_rise,
    input  logic                 sclk_rise,
    input  logic                 sdat,
    output logic                 frm_vld,
    output logic [ADDR_BITS-1:0] frm_addr,
    output word_t                frm_data
);

    localparam int CNT_W   = $clog2(FRAME_BITS + 2);
    localparam int CNT_MAX = FRAME_BITS + 1;

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic [CNT_W-1:0]      cnt;
        logic                  vld;
        logic [ADDR_BITS-1:0]  addr;
        word_t                 data;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      hdr_ok;

    assign hdr_ok = (st_q.shreg[FRAME_BITS-1 -: HDR_BITS] == HDR_VALUE);

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!enable) begin
            st_d.shreg = '0;
            st_d.cnt   = '0;
        end else if (sel_rise) begin
            if (st_q.cnt == CNT_W'(FRAME_BITS) && hdr_ok) begin
                st_d.vld  = 1'b1;
                st_d.addr = st_q.shreg[WORD_BITS +: ADDR_BITS];
                st_d.data = st_q.shreg[WORD_BITS-1:0];
            end
            st_d.cnt = '0;
        end else if (sel_n) begin
            st_d.cnt = '0;
        end else if (sclk_rise) begin
            st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], sdat};
            if (st_q.cnt != CNT_W'(CNT_MAX)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign frm_vld  = st_q.vld;
    assign frm_addr = st_q.addr;
    assign frm_data = st_q.data;

    // A frame is only emitted after exactly 32 captured bits.
    assert_len_exact_R3: assert property (@(posedge clk) disable iff (rst)
        st_q.vld |-> $past(st_q.cnt) == CNT_W'(FRAME_BITS));

    // The bit counter saturates one beyond the frame length.
    assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_W'(CNT_MAX));

    // An emitted frame carried the fixed header.
    assert_hdr_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.vld |-> $past(st_q.shreg[FRAME_BITS-1 -: HDR_BITS]) == HDR_VALUE);

    // With the port disabled no frame is emitted.
    assert_ext_off_R4: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !st_q.vld);

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_vld,
    input  logic [ADDR_BITS-1:0]               wr_addr,
    input  word_t                              wr_data,
    output logic [NUM_REGS-1:0][WORD_BITS-1:0] regs,
    output logic                               all_written
);

    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_BITS-1:0] regs;
        logic [NUM_REGS-1:0]                wr;
    } rf_state_t;

    rf_state_t st_d, st_q;
    slot_t     tgt;
    word_t     val;
    logic      accept;

    always_comb begin
        tgt    = slot_of(wr_addr);
        val    = wr_data;
        accept = wr_vld && tgt.ok;
        if (int'(tgt.idx) == SLOT_CFG && !wr_data[CFG_DDRN_BIT]) begin
            val[CFG_OE_BIT] = 1'b0;
        end
        if (int'(tgt.idx) == SLOT_DES && !st_q.wr[SLOT_DES]
            && wr_data != DES_INIT_WORD) begin
            accept = 1'b0;
        end

        st_d = st_q;
        if (accept) begin
            st_d.regs[tgt.idx] = val;
            st_d.wr[tgt.idx]   = 1'b1;
        end
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                st_d.regs[i] = reset_word(i);
            end
            st_d.wr = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs        = st_q.regs;
    assign all_written = &st_q.wr;

    // Stored config never holds output enable together with DDR mode.
    assert_oe_ddr_R6: assert property (@(posedge clk) disable iff (rst)
        !st_q.regs[SLOT_CFG][CFG_DDRN_BIT] |-> !st_q.regs[SLOT_CFG][CFG_OE_BIT]);

    // The dual-edge register is first marked written only by the init word.
    assert_des_first_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.wr[SLOT_DES]) |-> $past(wr_data) == DES_INIT_WORD);

    // Without an incoming frame no register moves.
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_vld |=> $stable(st_q.regs));

    // Unmapped addresses never mark anything written.
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && !slot_of(wr_addr).ok) |=> $stable(st_q.wr));

endmodule

// File: rtl/serial_cfg_slave.sv
module serial_cfg_slave
    import cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ext_mode_i,
    input  logic                 sel_n_i,
    input  logic                 sclk_i,
    input  logic                 sdat_i,
    output logic                 ddr_n_o,
    output logic                 ddr_phase_o,
    output logic                 out_en_o,
    output logic                 out_lvl_o,
    output logic [TRIM_BITS-1:0] offset_o,
    output logic [TRIM_BITS-1:0] fs_adj_o,
    output logic                 des_en_o,
    output logic                 auto_phase_o,
    output logic [WORD_BITS-1:0] coarse_o,
    output logic [WORD_BITS-1:0] fine_o
);

    localparam int PIN_N   = 4;
    localparam int P_SDAT  = 0;
    localparam int P_SCLK  = 1;
    localparam int P_SEL   = 2;
    localparam int P_EXT   = 3;
    localparam logic [PIN_N-1:0] PIN_IDLE = 4'b0100;

    logic [PIN_N-1:0]                   pins_s, pins_r;
    logic                               frm_vld;
    logic [ADDR_BITS-1:0]               frm_addr;
    word_t                              frm_data;
    logic [NUM_REGS-1:0][WORD_BITS-1:0] regs;
    logic                               all_wr;
    logic                               unused_rise;

    cfg_sync_edge #(
        .WIDTH   (PIN_N),
        .STAGES  (2),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ext_mode_i, sel_n_i, sclk_i, sdat_i}),
        .dout (pins_s),
        .rise (pins_r)
    );

    assign unused_rise = pins_r[P_SDAT] ^ pins_r[P_EXT];

    cfg_frame_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .enable    (pins_s[P_EXT]),
        .sel_n     (pins_s[P_SEL]),
        .sel_rise  (pins_r[P_SEL]),
        .sclk_rise (pins_r[P_SCLK]),
        .sdat      (pins_s[P_SDAT]),
        .frm_vld   (frm_vld),
        .frm_addr  (frm_addr),
        .frm_data  (frm_data)
    );

    cfg_regfile u_rf (
        .clk         (clk),
        .rst         (rst),
        .wr_vld      (frm_vld),
        .wr_addr     (frm_addr),
        .wr_data     (frm_data),
        .regs        (regs),
        .all_written (all_wr)
    );

    assign out_en_o     = regs[SLOT_CFG][CFG_OE_BIT];
    assign out_lvl_o    = regs[SLOT_CFG][CFG_LVL_BIT];
    assign ddr_n_o      = regs[SLOT_CFG][CFG_DDRN_BIT];
    assign ddr_phase_o  = regs[SLOT_CFG][CFG_PHASE_BIT];
    assign offset_o     = regs[SLOT_OFS][WORD_BITS-1:TRIM_LSB];
    assign fs_adj_o     = regs[SLOT_FS][WORD_BITS-1:TRIM_LSB];
    assign des_en_o     = regs[SLOT_DES][DES_EN_BIT] & all_wr;
    assign auto_phase_o = regs[SLOT_DES][DES_AUTO_BIT];
    assign coarse_o     = regs[SLOT_COARSE];
    assign fine_o       = regs[SLOT_FINE];

    logic [WORD_BITS*3-1:0] unused_bits;
    assign unused_bits = {regs[SLOT_SPARE0], regs[SLOT_SPARE4], regs[SLOT_DES]};

    // Dual-edge enable can only rise while every register is written.
    assert_des_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(des_en_o) |-> all_wr);

endmodule

// File: tb/serial_cfg_slave_bench.sv
module serial_cfg_slave_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext = 1'b0;
    logic sel_n = 1'b1;
    logic sclk = 1'b0;
    logic sdat = 1'b0;

    logic       ddr_n, ddr_phase, out_en, out_lvl, des_en, auto_phase;
    logic [8:0] offset, fs_adj;
    logic [15:0] coarse, fine;

    always #4 clk = ~clk;

    serial_cfg_slave u_serial_cfg_slave (
        .clk          (clk),
        .rst          (rst),
        .ext_mode_i   (ext),
        .sel_n_i      (sel_n),
        .sclk_i       (sclk),
        .sdat_i       (sdat),
        .ddr_n_o      (ddr_n),
        .ddr_phase_o  (ddr_phase),
        .out_en_o     (out_en),
        .out_lvl_o    (out_lvl),
        .offset_o     (offset),
        .fs_adj_o     (fs_adj),
        .des_en_o     (des_en),
        .auto_phase_o (auto_phase),
        .coarse_o     (coarse),
        .fine_o       (fine)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    busy     = 1'b1;
    bit    done     = 1'b0;
    string phase_tag = "R1";

    // Behavioural model: one word and one written flag per address.
    logic [15:0] m_word [16];
    bit          m_wr   [16];

    function automatic bit mapped(input int a);
        return (a <= 4) || (a >= 13);
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 16; a++) begin
            m_word[a] = 16'h0000;
            m_wr[a]   = 1'b0;
        end
        m_word[1]  = 16'h0200;
        m_word[3]  = 16'h8000;
        m_word[13] = 16'h3FFF;
    endtask

    function automatic bit model_all_written();
        bit r = 1'b1;
        for (int a = 0; a < 16; a++) begin
            if (mapped(a) && !m_wr[a]) r = 1'b0;
        end
        return r;
    endfunction

    task automatic model_frame(input logic [31:0] w, input int nbits);
        int          a;
        logic [15:0] v;
        if (!ext || nbits != 32 || w[31:20] != 12'h001) return;
        a = int'(w[19:16]);
        v = w[15:0];
        if (!mapped(a)) return;
        if (a == 1 && v[10] == 1'b0) v[8] = 1'b0;
        if (a == 13 && !m_wr[13] && v != 16'h3FFF) return;
        m_word[a] = v;
        m_wr[a]   = 1'b1;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s: actual 0x%0h expected 0x%0h", tag, phase_tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk("R5", "out_en",    int'(out_en),    int'(m_word[1][8]));
        chk("R5", "out_lvl",   int'(out_lvl),   int'(m_word[1][9]));
        chk("R5", "ddr_n",     int'(ddr_n),     int'(m_word[1][10]));
        chk("R5", "ddr_phase", int'(ddr_phase), int'(m_word[1][11]));
        chk("R7", "offset",    int'(offset),    int'(m_word[2][15:7]));
        chk("R7", "fs_adj",    int'(fs_adj),    int'(m_word[3][15:7]));
        chk("R8", "des_en",    int'(des_en),    int'(m_word[13][15] && model_all_written()));
        chk("R8", "auto_phase",int'(auto_phase),int'(m_word[13][14]));
        chk("R11", "coarse",   int'(coarse),    int'(m_word[14]));
        chk("R11", "fine",     int'(fine),      int'(m_word[15]));
    endtask

    // Continuous comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!busy && !rst && !done) check_outputs();
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [31:0] w, input int nbits);
        wait_clk(1);
        sel_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sdat = (i < 32) ? w[31-i] : 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
        busy  = 1'b1;
        sel_n = 1'b1;
        wait_clk(14);
        model_frame(w, nbits);
        busy = 1'b0;
    endtask

    function automatic logic [31:0] frame(input logic [3:0] a, input logic [15:0] v);
        return {12'h001, a, v};
    endfunction

    task automatic do_reset();
        busy = 1'b1;
        wait_clk(1);
        rst = 1'b1;
        wait_clk(5);
        rst = 1'b0;
        model_reset();
        wait_clk(4);
        busy = 1'b0;
    endtask

    initial begin
        model_reset();
        do_reset();
        phase_tag = "R1";
        check_outputs();

        phase_tag = "R4";
        ext = 1'b0;
        send(frame(4'h1, 16'h0F00), 32);
        chk("R4", "ddr_n untouched", int'(ddr_n), 0);

        ext = 1'b1;
        wait_clk(6);
        phase_tag = "R2";
        send(frame(4'h1, 16'h0F00), 32);
        chk("R2", "out_en after write", int'(out_en), 1);
        chk("R5", "ddr_phase after write", int'(ddr_phase), 1);

        phase_tag = "R6";
        send(frame(4'h1, 16'h0100), 32);
        chk("R6", "out_en forced in DDR", int'(out_en), 0);

        phase_tag = "R7";
        send(frame(4'h2, 16'hFF80), 32);
        send(frame(4'h3, 16'h0080), 32);
        chk("R7", "offset max", int'(offset), 511);
        chk("R7", "fs_adj one", int'(fs_adj), 1);

        phase_tag = "R3";
        send({12'h002, 4'h2, 16'h1234}, 32);
        send(frame(4'h2, 16'h5555), 31);
        send(frame(4'h2, 16'h2A80), 33);
        chk("R3", "offset kept", int'(offset), 511);

        phase_tag = "R9";
        send(frame(4'hD, 16'hC000), 32);
        chk("R9", "auto_phase after refused", int'(auto_phase), 0);
        send(frame(4'hD, 16'h3FFF), 32);
        phase_tag = "R8";
        send(frame(4'hD, 16'h8000), 32);
        chk("R8", "des_en before all written", int'(des_en), 0);

        phase_tag = "R11";
        send(frame(4'h0, 16'h1234), 32);
        send(frame(4'hE, 16'h0ABC), 32);
        send(frame(4'hF, 16'h0DEF), 32);
        chk("R11", "coarse", int'(coarse), 16'h0ABC);

        phase_tag = "R10";
        send(frame(4'h5, 16'h5555), 32);
        chk("R10", "des_en after unmapped", int'(des_en), 0);
        send(frame(4'h4, 16'h00FF), 32);
        chk("R8", "des_en after all written", int'(des_en), 1);

        phase_tag = "R8";
        send(frame(4'hD, 16'h4000), 32);
        chk("R8", "auto_phase", int'(auto_phase), 1);
        chk("R8", "des_en cleared", int'(des_en), 0);
        send(frame(4'h1, 16'h0500), 32);
        chk("R5", "out_en in SDR", int'(out_en), 1);

        phase_tag = "R12";
        do_reset();
        check_outputs();
        chk("R12", "fs_adj default", int'(fs_adj), 256);
        send(frame(4'hD, 16'hC000), 32);
        chk("R12", "first-write rule rearmed", int'(auto_phase), 0);
        send(frame(4'hD, 16'h7FFF), 32);
        chk("R9", "second write refused too", int'(auto_phase), 0);

        wait_clk(4);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule